// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a processor subsystem, reached through a small register bus with three word registers. A control register at offset 0x0 takes keyed commands. A mode register at offset 0x4 holds the configuration. A status register at offset 0x8 reports faults.

A 12-bit down-counter advances once per `tick_i` pulse. The tick comes from an external slow clock at 256 pulses per second, so a timeout of N seconds (1 to 16) needs a reload value of N*256-1. Software must restart the counter before it runs out. A restart only counts as valid once the counter has fallen to or below the delta value. A restart issued while the counter is still above the delta value is an early-restart error. Both an underflow and an early restart record a status bit and drive the configured fault outputs: an interrupt, a reset request, or both.

Software can rewrite the mode register any number of times until it issues a keyed lock command. From then until reset, the mode register cannot change. Counting can be paused while the debug-halt or idle input is high, with each pause condition enabled by its own mode bit.

Top module: `win_wdt`

## Requirements
- R1: After reset, the mode register reads 0x0FFF_2FFF: reload 0xFFF in bits 11:0, delta 0xFFF in bits 27:16, reset-request enable (bit 13) set, and the block enabled. The status register reads 0, and `irq_o`, `rst_req_o` and `rst_proc_only_o` are low.
- R2: While enabled and not halted, each `tick_i` pulse decrements the counter. A tick that finds the counter at 0 sets status bit 0 (underflow) and reloads the counter from bits 11:0. An accepted mode write also reloads the counter, so a reload R faults on tick R+1.
- R3: A control write with 0xA5 in bits 31:24 and bit 0 set restarts the counter from the reload value. A control write carrying any other key has no effect.
- R4: If a valid restart arrives while the counter is strictly greater than the delta value (bits 27:16), status bit 1 (early-restart error) is set. A restart with the counter at or below the delta value sets no error.
- R5: Mode register writes are accepted repeatedly until a control write with key 0xA5 and bit 4 set. From then until reset, every mode write is ignored, including one that sets the disable bit. A lock command with a wrong key does not lock.
- R6: A mode write with bit 15 (disable) set updates the other bits but leaves bits 11:0 and 27:16 unchanged. While bit 15 is set, the counter neither counts nor underflows, and restarts are ignored.
- R7: With mode bit 28 set, counting stops while `dbg_halt_i` is high. With mode bit 29 set, counting stops while `idle_i` is high. With a bit clear, its input has no effect.
- R8: A status read returns {30'b0, early_error, underflow} one cycle after the request and clears both bits. An event in the same cycle as the read still sets its bit.
- R9: `irq_o` is high while any status bit is set and mode bit 12 is set. `rst_req_o` is high while any status bit is set and mode bit 13 is set. `rst_proc_only_o` equals `rst_req_o` gated by mode bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Byte address: 0x0 control, 0x4 mode, 0x8 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| tick_i | input | 1 | Slow count enable, one pulse per count |
| dbg_halt_i | input | 1 | Debug halt indication |
| idle_i | input | 1 | Idle indication |
| irq_o | output | 1 | Fault interrupt |
| rst_req_o | output | 1 | Reset request |
| rst_proc_only_o | output | 1 | Reset request scoped to the processor only |

## Verification
The checker watches several properties on every cycle:
- once locked, the block stays locked and the mode register holds its value;
- a disabled or halted counter holds still;
- a control write with a wrong key leaves the counter alone;
- a disable write keeps the timing fields;
- a status read with no concurrent event leaves both bits clear;
- an underflow with interrupts enabled raises the interrupt.

Only the bench scenarios can show the exact tick on which an underflow lands for a given reload. They also cover the edges of the restart window, the pairing of each halt input with its own mode bit, and whether each fault output follows its enable bit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 4;
  localparam int unsigned CNT_W  = 12;
  localparam logic [7:0]  KEY    = 8'hA5;

  localparam logic [AW-1:0] ADDR_CTRL = 4'h0;
  localparam logic [AW-1:0] ADDR_MODE = 4'h4;
  localparam logic [AW-1:0] ADDR_STAT = 4'h8;

  // mode register bit positions
  localparam int unsigned M_RLD_LO = 0;
  localparam int unsigned M_FIEN   = 12;
  localparam int unsigned M_RSTEN  = 13;
  localparam int unsigned M_PROC   = 14;
  localparam int unsigned M_DIS    = 15;
  localparam int unsigned M_DLT_LO = 16;
  localparam int unsigned M_DBGH   = 28;
  localparam int unsigned M_IDLEH  = 29;

  // control register bit positions
  localparam int unsigned C_RESTART = 0;
  localparam int unsigned C_LOCK    = 4;
  localparam int unsigned C_KEY_LO  = 24;

  localparam logic [DW-1:0] MODE_MASK = 32'h3FFF_FFFF;
  localparam logic [DW-1:0] MODE_RST  = 32'h0FFF_2FFF;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic          locked_o,
  output logic          restart_o,
  output logic          mode_ld_o
);
  logic          key_ok, ctrl_wr, lock_set;
  logic [DW-1:0] mode_q, mode_d;

  assign ctrl_wr   = req_i && we_i && (sel_i == SEL_CTRL);
  assign key_ok    = (wdata_i[C_KEY_LO +: 8] == KEY);
  assign restart_o = ctrl_wr && key_ok && wdata_i[C_RESTART];
  assign lock_set  = ctrl_wr && key_ok && wdata_i[C_LOCK];
  assign mode_ld_o = req_i && we_i && (sel_i == SEL_MODE) && !locked_o;

  always_comb begin
    mode_d = wdata_i & MODE_MASK;
    if (wdata_i[M_DIS]) begin
      // timing fields frozen by a disabling write
      mode_d[M_RLD_LO +: CNT_W] = mode_q[M_RLD_LO +: CNT_W];
      mode_d[M_DLT_LO +: CNT_W] = mode_q[M_DLT_LO +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      locked_o <= 1'b0;
    end else begin
      if (mode_ld_o) mode_q <= mode_d;
      if (lock_set)  locked_o <= 1'b1;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             enable_i,
  input  logic             mode_ld_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic [CNT_W-1:0] new_reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             unf_evt_o,
  output logic             err_evt_o
);
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             rst_ok, step;

  assign rst_ok    = restart_i && enable_i;
  assign step      = run_i && tick_i && !mode_ld_i && !rst_ok;
  assign unf_evt_o = step && (cnt_q == '0);
  assign err_evt_o = rst_ok && (cnt_q > delta_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= CNT_RST;
    else if (mode_ld_i) cnt_q <= new_reload_i;
    else if (rst_ok)    cnt_q <= reload_i;
    else if (step)      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unf_evt_i,
  input  logic       err_evt_i,
  input  logic       clr_i,
  output logic [1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= 2'b00;
    else begin
      stat_o[0] <= unf_evt_i || (stat_o[0] && !clr_i);
      stat_o[1] <= err_evt_i || (stat_o[1] && !clr_i);
    end
  end
endmodule

// File: rtl/win_wdt.sv
module win_wdt
  import wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  input  logic          dbg_halt_i,
  input  logic          idle_i,
  output logic          irq_o,
  output logic          rst_req_o,
  output logic          rst_proc_only_o
);
  reg_sel_e         sel;
  logic [DW-1:0]    mode_q;
  logic             locked_q, restart, mode_ld, enabled, halted, run;
  logic [CNT_W-1:0] cnt_q;
  logic             unf_evt, err_evt, stat_rd, fault;
  logic [1:0]       stat_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: sel = SEL_CTRL;
      ADDR_MODE: sel = SEL_MODE;
      ADDR_STAT: sel = SEL_STAT;
      default:   sel = SEL_NONE;
    endcase
  end

  wdt_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i,
    .sel_i     (sel),
    .wdata_i,
    .mode_o    (mode_q),
    .locked_o  (locked_q),
    .restart_o (restart),
    .mode_ld_o (mode_ld)
  );

  assign enabled = !mode_q[M_DIS];
  assign halted  = (mode_q[M_DBGH] && dbg_halt_i) || (mode_q[M_IDLEH] && idle_i);
  assign run     = enabled && !halted;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .run_i        (run),
    .enable_i     (enabled),
    .mode_ld_i    (mode_ld),
    .restart_i    (restart),
    .reload_i     (mode_q[M_RLD_LO +: CNT_W]),
    .delta_i      (mode_q[M_DLT_LO +: CNT_W]),
    .new_reload_i (wdata_i[M_DIS] ? mode_q[M_RLD_LO +: CNT_W] : wdata_i[M_RLD_LO +: CNT_W]),
    .cnt_o        (cnt_q),
    .unf_evt_o    (unf_evt),
    .err_evt_o    (err_evt)
  );

  assign stat_rd = req_i && !we_i && (sel == SEL_STAT);

  wdt_status u_stat (
    .clk_i, .rst_ni,
    .unf_evt_i (unf_evt),
    .err_evt_i (err_evt),
    .clr_i     (stat_rd),
    .stat_o    (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) begin
      unique case (sel)
        SEL_MODE: rdata_o <= mode_q;
        SEL_STAT: rdata_o <= {{(DW-2){1'b0}}, stat_q};
        default:  rdata_o <= '0;
      endcase
    end
  end

  assign fault           = |stat_q;
  assign irq_o           = fault && mode_q[M_FIEN];
  assign rst_req_o       = fault && mode_q[M_RSTEN];
  assign rst_proc_only_o = rst_req_o && mode_q[M_PROC];
endmodule

// File: rtl/win_wdt_chk.sv
module win_wdt_chk
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             tick_i,
  input logic             dbg_halt_i,
  input logic             irq_o,
  input logic [DW-1:0]    mode_q,
  input logic             locked_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mode_ld,
  input logic             unf_evt,
  input logic             err_evt,
  input logic [1:0]       stat_q,
  input logic             stat_rd
);
  logic wrong_key_wr;
  assign wrong_key_wr = req_i && we_i && (addr_i == ADDR_CTRL) &&
                        (wdata_i[C_KEY_LO +: 8] != KEY);

  p_lock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  p_locked_mode_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(mode_q));

  p_wrong_key_no_effect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrong_key_wr && !tick_i && !mode_ld) |=> $stable(cnt_q));

  p_disabled_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[M_DIS] && !mode_ld) |=> $stable(cnt_q));

  p_dis_write_keeps_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ld && wdata_i[M_DIS]) |=>
      (mode_q[M_RLD_LO +: CNT_W] == $past(mode_q[M_RLD_LO +: CNT_W])) &&
      (mode_q[M_DLT_LO +: CNT_W] == $past(mode_q[M_DLT_LO +: CNT_W])));

  p_dbg_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[M_DBGH] && dbg_halt_i && !mode_ld && !(req_i && we_i && addr_i == ADDR_CTRL))
      |=> $stable(cnt_q));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !unf_evt && !err_evt) |=> (stat_q == 2'b00));

  p_unf_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_evt && mode_q[M_FIEN] && !mode_ld) |=> irq_o);
endmodule

bind win_wdt win_wdt_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .tick_i, .dbg_halt_i, .irq_o,
  .mode_q, .locked_q, .cnt_q, .mode_ld, .unf_evt, .err_evt, .stat_q, .stat_rd
);

// File: tb/win_wdt_tb.sv
module win_wdt_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_i = 1'b0, dbg_halt_i = 1'b0, idle_i = 1'b0;
  logic        irq_o, rst_req_o, rst_proc_only_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  win_wdt u_dut (.*);

  // {reload[23:12], ticks[11:4], expected status[3:0]}
  localparam logic [23:0] VEC [0:6] = '{
    24'h003_03_0, 24'h003_04_1, 24'h000_01_1, 24'h000_00_0,
    24'h007_08_1, 24'h005_05_0, 24'h001_02_1
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0; d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1;
      @(negedge clk_i); tick_i = 0;
    end
  endtask

  task automatic stat_is(string req, logic [31:0] exp);
    logic [31:0] d;
    rd(4'h8, d);
    chk(req, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    chk("R1 outputs", {29'b0, irq_o, rst_req_o, rst_proc_only_o}, 32'h0);
    rd(4'h4, d); chk("R1 mode", d, 32'h0FFF_2FFF);
    stat_is("R1 status", 32'h0);

    // R2 table walk
    for (int v = 0; v < 7; v++) begin
      wr(4'h4, 32'h0FFF_2000 | {20'b0, VEC[v][23:12]});
      ticks(int'(VEC[v][11:4]));
      @(negedge clk_i);
      chk("R9 rst_req level", {31'b0, rst_req_o}, {31'b0, VEC[v][3:0] != 0});
      stat_is("R2 underflow timing", {28'b0, VEC[v][3:0]});
    end
    stat_is("R8 cleared after read", 32'h0);

    // R3 keys
    wr(4'h4, 32'h0FFF_2003); ticks(3);
    wr(4'h0, 32'h5A00_0001); ticks(1);
    stat_is("R3 wrong key ignored", 32'h1);
    wr(4'h4, 32'h0FFF_2003); ticks(3);
    wr(4'h0, 32'hA500_0001); ticks(3);
    stat_is("R3 restart reloads", 32'h0);
    ticks(1);
    stat_is("R3 underflow after restart", 32'h1);

    // R4 window
    wr(4'h4, 32'h0005_200A);
    wr(4'h0, 32'hA500_0001);
    stat_is("R4 immediate restart early", 32'h2);
    ticks(4); wr(4'h0, 32'hA500_0001);
    stat_is("R4 count 6 above delta 5", 32'h2);
    ticks(5); wr(4'h0, 32'hA500_0001);
    stat_is("R4 count equal delta ok", 32'h0);

    // R9 output routing
    wr(4'h4, 32'h0FFF_1002); ticks(3); @(negedge clk_i);
    chk("R9 irq only", {29'b0, irq_o, rst_req_o, rst_proc_only_o}, 32'h4);
    stat_is("R9 irq status", 32'h1);
    wr(4'h4, 32'h0FFF_6002); ticks(3); @(negedge clk_i);
    chk("R9 proc only", {29'b0, irq_o, rst_req_o, rst_proc_only_o}, 32'h3);
    stat_is("R9 proc status", 32'h1);

    // R7 halts
    dbg_halt_i = 1;
    wr(4'h4, 32'h1FFF_2002); ticks(10);
    stat_is("R7 debug halt", 32'h0);
    dbg_halt_i = 0; ticks(3);
    stat_is("R7 debug resume", 32'h1);
    idle_i = 1;
    wr(4'h4, 32'h2FFF_2002); ticks(10);
    stat_is("R7 idle halt", 32'h0);
    idle_i = 0; dbg_halt_i = 1; ticks(3);
    stat_is("R7 dbg ignored without bit28", 32'h1);
    dbg_halt_i = 0;

    // R6 disable
    wr(4'h4, 32'h0FFF_2002);
    wr(4'h4, 32'h0123_A456);
    rd(4'h4, d); chk("R6 fields kept", d, 32'h0FFF_A002);
    ticks(10); wr(4'h0, 32'hA500_0001);
    stat_is("R6 disabled no fault", 32'h0);
    wr(4'h4, 32'h0FFF_2002); ticks(3);
    stat_is("R6 re-enabled", 32'h1);

    // R5 lock
    wr(4'h0, 32'h1100_0010);
    wr(4'h4, 32'h0FFF_2005);
    rd(4'h4, d); chk("R5 wrong-key lock ignored", d, 32'h0FFF_2005);
    wr(4'h0, 32'hA500_0010);
    wr(4'h4, 32'h0FFF_2003);
    rd(4'h4, d); chk("R5 locked write ignored", d, 32'h0FFF_2005);
    wr(4'h4, 32'h0FFF_A005);
    ticks(6);
    stat_is("R5 locked disable ignored", 32'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule